// File: doc/BRIEF.md
# Ratiometric Millivolt Scaler

This block turns raw accumulated converter levels into signed millivolt readings. For each of its eight channels it holds no calibration itself. Instead it reads three level buffers from outside: the level taken with the input switched to ground, the level taken with the input switched to the supply, and the level of the real signal. When it is asked to convert one channel, it divides a full-scale constant (3300 mV in Q12 fixed point) by the span between the two reference levels. It then multiplies that quotient by the signal's offset above the ground level and drops the twelve fraction bits. The result goes into that channel's entry of a sample register file that can be read at any time.

The caller strobes `start` with a channel index. The block copies the selected channel's levels at once, so the caller may change the buffers afterwards. It computes the signal offset while a multi-cycle restoring divider works on the scale factor. When the quotient is ready, it does one multiply, writes the entry and pulses `done`. If a channel's supply reference is not above its ground reference, no scale can be formed. In that case the entry keeps its old value and a sticky error bit is set.

Top module: `mv_scaler`

## Requirements
- R1: After reset, every entry of `samples` is zero, `errSticky` is low, `busy` is low and `done` is low.
- R2: For an accepted conversion of channel `chanIdx`, span = supLvl[chanIdx] − gndLvl[chanIdx] (levels unsigned), and the scale is the integer quotient floor((3300 × 4096) / span).
- R3: The written value is ((sigLvl[chanIdx] − gndLvl[chanIdx]) × scale) shifted right arithmetically by 12 and held as a signed 32-bit two's-complement number. A signal below the ground level gives a negative value.
- R4: The result is written only to entry `chanIdx`, which sits at bits [32·i+31 : 32·i] of `samples` for channel i. Every other entry keeps its value.
- R5: When span is zero or negative, the selected entry keeps its previous value, `errSticky` is set, and `done` still pulses.
- R6: Once set, `errSticky` stays high through later successful conversions until reset.
- R7: A `start` raised while `busy` is high is ignored. No entry changes because of it and no extra `done` is produced.
- R8: `busy` is high from the cycle after a start is accepted until the result is written. `done` is a single-cycle pulse in the cycle after that write, and it arrives exactly once per accepted conversion.
- R9: The levels of the selected channel are captured in the cycle the start is accepted. Later changes to the level inputs do not affect that conversion's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a conversion of `chanIdx` (accepted when idle) |
| chanIdx | input | 3 | Channel to convert |
| gndLvl | input | 128 | Eight 16-bit ground-reference levels, channel i at [16i+15:16i] |
| supLvl | input | 128 | Eight 16-bit supply-reference levels |
| sigLvl | input | 128 | Eight 16-bit signal levels |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle pulse after a conversion completes or is rejected |
| errSticky | output | 1 | Set by a non-positive reference span, cleared only by reset |
| samples | output | 256 | Eight signed 32-bit millivolt results, entry i at [32i+31:32i] |

## Verification
The divider check assumes the divisor stays steady for the whole division. The sample-file checks assume that only the control strobes move the entries. Both rely on the caller not starting a new job mid-division, which the design enforces by ignoring starts while busy. The stimulus keeps levels within 16 bits and spans within the range where the full product fits in 42 bits, so every expected value has a single exact answer. It deliberately pokes `start` during a running conversion and changes the level buffers right after acceptance to probe the capture and ignore rules.

// File: rtl/mv_scaler_pkg.sv
package mv_scaler_pkg;
  // Strobes from the sequencer to the datapath.
  typedef struct packed {
    logic capture;  // latch index and selected levels
    logic kickDiv;  // begin the scale division
    logic write;    // commit the product to the sample file
    logic flagBad;  // span not positive: set sticky error, keep entry
  } mvs_ctrl_t;
endpackage

// File: rtl/mv_scaler_div.sv
module mv_scaler_div #(
  parameter int NW = 24,  // dividend / quotient width
  parameter int DW = 17   // divisor width
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic [NW-1:0] dividend,
  input  logic [DW-1:0] divisor,
  output logic          done,
  output logic [NW-1:0] quo
);
  localparam int CW = $clog2(NW + 1);
  localparam int PW = NW + DW + 1;

  logic [CW-1:0] cnt;
  logic          running;
  logic [DW-1:0] remR;
  logic [NW-1:0] quoR;
  logic [DW:0]   trial;
  logic          fits;
  logic [DW-1:0] reduced;

  assign trial   = {remR, quoR[NW-1]};
  assign fits    = trial >= {1'b0, divisor};
  assign reduced = trial[DW-1:0] - divisor;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt     <= '0;
      running <= 1'b0;
      remR    <= '0;
      quoR    <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !running) begin
        remR    <= '0;
        quoR    <= dividend;
        cnt     <= CW'(NW);
        running <= 1'b1;
      end else if (running) begin
        remR <= fits ? reduced : trial[DW-1:0];
        quoR <= {quoR[NW-2:0], fits};
        cnt  <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          running <= 1'b0;
          done    <= 1'b1;
        end
      end
    end
  end

  assign quo = quoR;

  // R2: a finished division is exact: quotient*divisor + remainder = dividend, remainder < divisor
  a_r2_div_exact: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ((PW'(quoR) * PW'(divisor) + PW'(remR)) == PW'(dividend)) && (remR < divisor));
endmodule

// File: rtl/mv_scaler_ctrl.sv
module mv_scaler_ctrl
  import mv_scaler_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      spanPos,
  input  logic      divDone,
  output mvs_ctrl_t ctl,
  output logic      busy,
  output logic      done
);
  typedef enum logic [1:0] {S_IDLE, S_CHECK, S_DIV, S_WRITE} state_t;
  state_t state, nextState;

  always_comb begin
    nextState = state;
    ctl       = '0;
    unique case (state)
      S_IDLE: if (start) begin
        ctl.capture = 1'b1;
        nextState   = S_CHECK;
      end
      S_CHECK: if (spanPos) begin
        ctl.kickDiv = 1'b1;
        nextState   = S_DIV;
      end else begin
        ctl.flagBad = 1'b1;
        nextState   = S_IDLE;
      end
      S_DIV: if (divDone) nextState = S_WRITE;
      S_WRITE: begin
        ctl.write = 1'b1;
        nextState = S_IDLE;
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      done  <= 1'b0;
    end else begin
      state <= nextState;
      done  <= ctl.write || ctl.flagBad;
    end
  end

  assign busy = (state != S_IDLE);

  // R8: completion is a single-cycle pulse
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R7: a start seen mid-conversion never restarts the capture step
  a_r7_start_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start) |=> (state != S_CHECK));
  // R8: the write step is only reached from a finished division
  a_r8_write_after_div: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_WRITE) |-> $past(divDone));
endmodule

// File: rtl/mv_scaler_dp.sv
module mv_scaler_dp
  import mv_scaler_pkg::*;
#(
  parameter int NCH     = 8,
  parameter int LW      = 16,
  parameter int RW      = 32,
  parameter int FULL_MV = 3300,
  parameter int FRAC    = 12
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  mvs_ctrl_t                      ctl,
  input  logic [$clog2(NCH)-1:0]         chanIdx,
  input  logic [NCH-1:0][LW-1:0]         gndLvl,
  input  logic [NCH-1:0][LW-1:0]         supLvl,
  input  logic [NCH-1:0][LW-1:0]         sigLvl,
  output logic                           spanPos,
  output logic                           divDone,
  output logic                           errSticky,
  output logic [NCH-1:0][RW-1:0]         samples
);
  localparam int IW = $clog2(NCH);
  localparam int NW = FRAC + $clog2(FULL_MV + 1);
  localparam int DW = LW + 1;
  localparam int PW = DW + NW + 1;
  localparam logic [NW-1:0] DIVIDEND = NW'(FULL_MV * (2 ** FRAC));

  logic [IW-1:0]        idxR;
  logic signed [DW-1:0] spanR;
  logic signed [DW-1:0] offsR;
  logic [NW-1:0]        scale;
  logic signed [PW-1:0] prod;
  logic signed [RW-1:0] result;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idxR  <= '0;
      spanR <= '0;
      offsR <= '0;
    end else if (ctl.capture) begin
      idxR  <= chanIdx;
      spanR <= $signed({1'b0, supLvl[chanIdx]}) - $signed({1'b0, gndLvl[chanIdx]});
      offsR <= $signed({1'b0, sigLvl[chanIdx]}) - $signed({1'b0, gndLvl[chanIdx]});
    end
  end

  assign spanPos = !spanR[DW-1] && (spanR != '0);

  mv_scaler_div #(.NW(NW), .DW(DW)) u_div (
    .clk      (clk),
    .rstN     (rstN),
    .start    (ctl.kickDiv),
    .dividend (DIVIDEND),
    .divisor  (spanR),
    .done     (divDone),
    .quo      (scale)
  );

  assign prod   = offsR * $signed({1'b0, scale});
  assign result = RW'(prod >>> FRAC);

  for (genvar i = 0; i < NCH; i++) begin : g_entry
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                samples[i] <= '0;
      else if (ctl.write && idxR == IW'(i))     samples[i] <= result;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            errSticky <= 1'b0;
    else if (ctl.flagBad) errSticky <= 1'b1;
  end

  // R4: the sample file moves only on a write strobe
  a_r4_no_stray_write: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.write |=> $stable(samples));
  // R5: a rejected span leaves samples alone and raises the error bit
  a_r5_hold_on_bad: assert property (@(posedge clk) disable iff (!rstN)
    ctl.flagBad |=> $stable(samples) && errSticky);
  // R6: error bit never falls outside reset
  a_r6_sticky: assert property (@(posedge clk) disable iff (!rstN)
    errSticky |=> errSticky);
  // R5: the division is only launched for a positive span
  a_r5_div_needs_span: assert property (@(posedge clk) disable iff (!rstN)
    ctl.kickDiv |-> spanPos);
endmodule

// File: rtl/mv_scaler.sv
module mv_scaler
  import mv_scaler_pkg::*;
#(
  parameter int NCH     = 8,
  parameter int LW      = 16,
  parameter int RW      = 32,
  parameter int FULL_MV = 3300,
  parameter int FRAC    = 12
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   start,
  input  logic [$clog2(NCH)-1:0] chanIdx,
  input  logic [NCH-1:0][LW-1:0] gndLvl,
  input  logic [NCH-1:0][LW-1:0] supLvl,
  input  logic [NCH-1:0][LW-1:0] sigLvl,
  output logic                   busy,
  output logic                   done,
  output logic                   errSticky,
  output logic [NCH-1:0][RW-1:0] samples
);
  mvs_ctrl_t ctl;
  logic      spanPos;
  logic      divDone;

  mv_scaler_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .spanPos (spanPos),
    .divDone (divDone),
    .ctl     (ctl),
    .busy    (busy),
    .done    (done)
  );

  mv_scaler_dp #(
    .NCH(NCH), .LW(LW), .RW(RW), .FULL_MV(FULL_MV), .FRAC(FRAC)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .chanIdx   (chanIdx),
    .gndLvl    (gndLvl),
    .supLvl    (supLvl),
    .sigLvl    (sigLvl),
    .spanPos   (spanPos),
    .divDone   (divDone),
    .errSticky (errSticky),
    .samples   (samples)
  );
endmodule

// File: tb/mv_scaler_test.sv
module mv_scaler_test;
  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             start = 1'b0;
  logic [2:0]       chanIdx = '0;
  logic [7:0][15:0] gndLvl = '0;
  logic [7:0][15:0] supLvl = '0;
  logic [7:0][15:0] sigLvl = '0;
  logic             busy, done, errSticky;
  logic [7:0][31:0] samples;

  mv_scaler uut (
    .clk(clk), .rstN(rstN), .start(start), .chanIdx(chanIdx),
    .gndLvl(gndLvl), .supLvl(supLvl), .sigLvl(sigLvl),
    .busy(busy), .done(done), .errSticky(errSticky), .samples(samples)
  );

  always #10 clk = ~clk;

  typedef struct {int idx; int val; bit err;} exp_t;
  exp_t expQ[$];
  int   model [8];
  bit   stickyModel = 1'b0;
  int   nRun = 0, nFail = 0;
  bit   finished = 1'b0;

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int calc(input int g, input int s, input int x);
    longint q, p;
    q = (longint'(3300) * 4096) / longint'(s - g);
    p = longint'(x - g) * q;
    return int'(p >>> 12);
  endfunction

  // Driver: load levels, predict the result, pulse start.
  task automatic convert(input int idx, input int g, input int s, input int x);
    exp_t e;
    @(negedge clk);
    while (busy || expQ.size() != 0) @(negedge clk);
    gndLvl[idx] = 16'(g); supLvl[idx] = 16'(s); sigLvl[idx] = 16'(x);
    chanIdx = 3'(idx);
    e.idx = idx;
    if (s - g > 0) model[idx] = calc(g, s, x);  // R2 R3
    else stickyModel = 1'b1;                     // R5
    e.val = model[idx];
    e.err = stickyModel;
    expQ.push_back(e);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic drain();
    @(negedge clk);
    while (busy || expQ.size() != 0) @(negedge clk);
  endtask

  // Monitor: compare each completion against the scoreboard.
  always @(negedge clk) begin
    if (rstN && done) begin
      if (expQ.size() == 0) check(1'b0, "R8 unexpected done", 1, 0);
      else begin
        exp_t e;
        e = expQ.pop_front();
        check($signed(samples[e.idx]) == e.val, "R3 R4 sample value", $signed(samples[e.idx]), e.val);
        check(errSticky == e.err, "R5 R6 errSticky", errSticky, e.err);
      end
    end
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      check(1'b0, "watchdog", 0, 1);
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) model[i] = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(samples == '0, "R1 samples zero", samples[0], 0);
    check(!errSticky && !busy && !done, "R1 flags low", {errSticky, busy, done}, 0);
    rstN = 1'b1;
    @(negedge clk);

    convert(0, 100, 3400, 1750);   // R3 exact scale 4096 -> 1650
    drain();
    check($signed(samples[0]) == 1650, "R3 exact midpoint", $signed(samples[0]), 1650);
    convert(1, 500, 2500, 300);    // R3 below ground -> negative
    convert(2, 0, 1000, 1500);     // R3 above supply
    convert(3, 0, 65535, 65535);   // R2 widest span
    convert(4, 1000, 1001, 1003);  // R2 span one
    for (int i = 0; i < 8; i++)    // R4 every entry
      convert(i, 37 * i + 20, 4000 - 111 * i, 1200 + 301 * i);
    drain();

    // R8: busy during run, single done
    convert(5, 10, 3000, 2000);
    check(busy, "R8 busy after accept", busy, 1);
    drain();
    check(!busy, "R8 idle after done", busy, 0);

    // R9: levels changed right after acceptance must not matter
    convert(6, 200, 3200, 900);
    gndLvl[6] = 16'd5000; supLvl[6] = 16'd1; sigLvl[6] = 16'd7;
    drain();

    // R7: start while busy is ignored (channel 7 left alone)
    convert(2, 50, 2050, 1000);
    @(negedge clk);
    gndLvl[7] = 16'd0; supLvl[7] = 16'd100; sigLvl[7] = 16'd99;
    chanIdx = 3'd7; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    drain();
    repeat (40) @(negedge clk);
    check($signed(samples[7]) == model[7], "R7 busy start ignored", $signed(samples[7]), model[7]);
    check(!busy, "R7 no extra run", busy, 0);

    // R5: zero and negative span hold entry and set sticky
    convert(3, 800, 800, 900);
    convert(1, 900, 100, 500);
    drain();
    check(errSticky, "R5 sticky set", errSticky, 1);
    // R6: later good conversion keeps sticky
    convert(4, 0, 3300, 3300);
    drain();
    check(errSticky, "R6 sticky kept", errSticky, 1);

    // R1: reset clears everything again
    rstN = 1'b0;
    stickyModel = 1'b0;
    repeat (2) @(negedge clk);
    check(samples == '0 && !errSticky, "R1 reset clears", errSticky, 0);
    rstN = 1'b1;

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule